// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block reads a twelve-key push-button pad wired as three column lines, which the block drives, and four row lines, which it senses. In scanning mode it raises one column at a time for a fixed dwell period. At the end of each dwell it takes a synchronized copy of the rows. Once all three columns have been sampled, the result is one full scan: a twelve-bit picture of the pad. The buttons have no hardware filtering, so the block debounces in logic. A press is reported only after the same key has been seen high on a number of consecutive full scans. A release is reported only after the same number of consecutive scans with no key high.

On acceptance the block emits a four-bit code equal to the key's printed legend, pulses a strobe for one clock, and holds a key-down flag until release. When several keys are down, the first one in scan order wins, and nothing new is reported until the whole pad has been released.

A parameter selects a static variant. In that variant one chosen column is held high permanently and its four rows are read on every dwell, which serves designs that only use four keys.

The debounce controller has four named states. IDLE waits for any key. CONFIRM counts scans on which the candidate key is still high. HELD holds the accepted key. RELEASE counts empty scans. The transitions are taken only at the end of a full scan:
- IDLE to CONFIRM when any key is high.
- CONFIRM to IDLE when the candidate reads low.
- CONFIRM to HELD (accept) when the required count is reached.
- HELD to RELEASE when the scan is empty.
- RELEASE to HELD when any key reappears.
- RELEASE to IDLE (release) when the required count of empty scans is reached.

With a count of one, IDLE goes straight to HELD and HELD goes straight to IDLE.

Top module: `keypad_scan`

## Requirements
- R1: In scanning mode exactly one bit of `col_drive` is high. It starts at column 0 (`3'b001`) after reset, steps 0, 1, 2, 0, and so on, and each column stays high for `DWELL` clocks.
- R2: In static mode `col_drive` is fixed at the one-hot code of `STATIC_COL`. Keys in the other columns have no effect on `key_valid`, `key_down` or `key_code`. Every dwell period counts as a full scan.
- R3: Rows are active-high, so a 1 on `row_sense[r]` means the key in row r of the driven column is pressed. The row value used for a column is the one present two clocks before that column's last dwell clock, because it passes through a two-flop synchronizer. It is taken on the last clock of the dwell.
- R4: A press is accepted at the end of the `DEBOUNCE`-th consecutive full scan in which the candidate key reads high. A scan in which the candidate reads low discards the count.
- R5: `key_valid` is high for exactly one clock per accepted press. It rises in the clock after the scan that completes the count, together with `key_down`.
- R6: Key index is column×4 + row. The codes are: column 0 rows 0 to 3 give 1, 4, 7, 0xC; column 1 gives 2, 5, 8, 0; column 2 gives 3, 6, 9, 0xE. `key_code` holds the code of the last accepted key.
- R7: `key_down` stays high, and `key_code` is stable, until `DEBOUNCE` consecutive full scans read no key. `key_down` then drops in the clock after that scan.
- R8: When several keys are high, the candidate is the lowest key index. No new strobe is raised while any key stays high after an acceptance.
- R9: After synchronous reset `col_drive` is column 0 (or `STATIC_COL` in static mode), and `key_valid`, `key_down` and `key_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_drive | output | 3 | One-hot column drive |
| row_sense | input | 4 | Row sense lines, active high |
| key_code | output | 4 | Legend code of accepted key |
| key_valid | output | 1 | One-clock strobe on accepted press |
| key_down | output | 1 | High while the accepted key is held |

## Verification
The hardest behaviour to reach from the ports is a run that is broken just short of the debounce count. The stimulus therefore holds a key for one scan and releases it for one scan, several times over. Because a press window one scan long covers exactly one sample of each column, the run of high scans never exceeds one, and no strobe may appear. The same is true of the case where a second key keeps the pad busy after the first is released, so that an acceptance must not repeat. That case is reached by releasing the winning key of a two-key press while the other key stays down for longer than the release count.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int unsigned NCOL = 3;
    localparam int unsigned NROW = 4;
    localparam int unsigned NKEY = NCOL * NROW;

    typedef logic [3:0] key_code_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_HELD,
        ST_RELEASE
    } kp_state_e;

    // legend of the key at index col*NROW + row
    function automatic key_code_t key_legend(input int unsigned idx);
        int unsigned c;
        int unsigned r;
        c = idx / NROW;
        r = idx % NROW;
        if (r < 3) begin
            key_legend = 4'(r * 3 + c + 1);
        end else if (c == 0) begin
            key_legend = 4'hC;
        end else if (c == 1) begin
            key_legend = 4'h0;
        end else begin
            key_legend = 4'hE;
        end
    endfunction
endpackage

// File: rtl/kp_col_seq.sv
module kp_col_seq
    import kp_pkg::*;
#(
    parameter int unsigned DWELL       = 1000,
    parameter bit          STATIC_MODE = 1'b0,
    parameter int unsigned STATIC_COL  = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [NCOL-1:0]           col_drive,
    output logic [$clog2(NCOL)-1:0]   col_sel,
    output logic                      sample
);
    localparam int unsigned DW_W  = (DWELL > 2) ? $clog2(DWELL) : 1;
    localparam int unsigned SEL_W = $clog2(NCOL);

    logic [DW_W-1:0] dwell_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_cnt <= '0;
        end else if (dwell_cnt == DW_W'(DWELL - 1)) begin
            dwell_cnt <= '0;
        end else begin
            dwell_cnt <= dwell_cnt + 1'b1;
        end
    end

    assign sample = (dwell_cnt == DW_W'(DWELL - 1));

    generate
        if (STATIC_MODE) begin : g_static
            assign col_sel   = SEL_W'(STATIC_COL);
            assign col_drive = NCOL'(1) << STATIC_COL;
        end else begin : g_scan
            logic [SEL_W-1:0] col_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    col_q <= '0;
                end else if (sample) begin
                    col_q <= (col_q == SEL_W'(NCOL - 1)) ? '0 : col_q + 1'b1;
                end
            end
            assign col_sel   = col_q;
            assign col_drive = NCOL'(1) << col_q;
        end
    endgenerate
endmodule

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/kp_snap.sv
module kp_snap
    import kp_pkg::*;
#(
    parameter bit STATIC_MODE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample,
    input  logic [$clog2(NCOL)-1:0] col_sel,
    input  logic [NROW-1:0]         rows,
    output logic                    scan_done,
    output logic [NKEY-1:0]         scan_vec
);
    localparam int unsigned SEL_W = $clog2(NCOL);

    logic [NKEY-1:0] partial;

    assign scan_done = sample && (STATIC_MODE || col_sel == SEL_W'(NCOL - 1));

    always_comb begin
        scan_vec = partial;
        for (int c = 0; c < NCOL; c++) begin
            if (col_sel == SEL_W'(c)) begin
                scan_vec[c*NROW +: NROW] = rows;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            partial <= '0;
        end else if (scan_done) begin
            partial <= '0;
        end else if (sample) begin
            partial <= scan_vec;
        end
    end
endmodule

// File: rtl/kp_debounce_fsm.sv
module kp_debounce_fsm
    import kp_pkg::*;
#(
    parameter int unsigned DEBOUNCE = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_done,
    input  logic [NKEY-1:0] scan_vec,
    output logic            key_valid,
    output logic            key_down,
    output key_code_t       key_code
);
    localparam int unsigned CNT_W = $clog2(DEBOUNCE + 1);
    localparam int unsigned IDX_W = $clog2(NKEY);

    kp_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [IDX_W-1:0] cand, cand_n;
    logic [IDX_W-1:0] first_idx;
    logic             any_key;
    logic             accept, release_ev;

    // lowest index in scan order wins
    always_comb begin
        first_idx = '0;
        for (int i = NKEY - 1; i >= 0; i--) begin
            if (scan_vec[i]) first_idx = IDX_W'(i);
        end
    end

    assign any_key = |scan_vec;

    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        cand_n     = cand;
        accept     = 1'b0;
        release_ev = 1'b0;
        if (scan_done) begin
            unique case (state)
                ST_IDLE: begin
                    if (any_key) begin
                        cand_n = first_idx;
                        if (DEBOUNCE <= 1) begin
                            accept  = 1'b1;
                            state_n = ST_HELD;
                            cnt_n   = '0;
                        end else begin
                            state_n = ST_CONFIRM;
                            cnt_n   = CNT_W'(1);
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (scan_vec[cand]) begin
                        if (cnt == CNT_W'(DEBOUNCE - 1)) begin
                            accept  = 1'b1;
                            state_n = ST_HELD;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end else begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end
                end
                ST_HELD: begin
                    if (!any_key) begin
                        if (DEBOUNCE <= 1) begin
                            release_ev = 1'b1;
                            state_n    = ST_IDLE;
                            cnt_n      = '0;
                        end else begin
                            state_n = ST_RELEASE;
                            cnt_n   = CNT_W'(1);
                        end
                    end
                end
                ST_RELEASE: begin
                    if (!any_key) begin
                        if (cnt == CNT_W'(DEBOUNCE - 1)) begin
                            release_ev = 1'b1;
                            state_n    = ST_IDLE;
                            cnt_n      = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end else begin
                        state_n = ST_HELD;
                        cnt_n   = '0;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cand  <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            cand  <= cand_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            key_valid <= 1'b0;
            key_down  <= 1'b0;
            key_code  <= '0;
        end else begin
            key_valid <= accept;
            if (accept) begin
                key_code <= key_legend(int'(cand_n));
                key_down <= 1'b1;
            end else if (release_ev) begin
                key_down <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan
    import kp_pkg::*;
#(
    parameter int unsigned DWELL       = 1000,
    parameter int unsigned DEBOUNCE    = 3,
    parameter bit          STATIC_MODE = 1'b0,
    parameter int unsigned STATIC_COL  = 0
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] col_drive,
    input  logic [3:0] row_sense,
    output logic [3:0] key_code,
    output logic       key_valid,
    output logic       key_down
);
    logic [$clog2(NCOL)-1:0] col_sel;
    logic                    sample;
    logic [NROW-1:0]         rows_s;
    logic                    scan_done;
    logic [NKEY-1:0]         scan_vec;

    kp_col_seq #(
        .DWELL(DWELL), .STATIC_MODE(STATIC_MODE), .STATIC_COL(STATIC_COL)
    ) u_col (
        .clk(clk), .rst(rst), .col_drive(col_drive), .col_sel(col_sel), .sample(sample)
    );

    kp_row_sync #(.W(NROW)) u_sync (
        .clk(clk), .rst(rst), .d(row_sense), .q(rows_s)
    );

    kp_snap #(.STATIC_MODE(STATIC_MODE)) u_snap (
        .clk(clk), .rst(rst), .sample(sample), .col_sel(col_sel),
        .rows(rows_s), .scan_done(scan_done), .scan_vec(scan_vec)
    );

    kp_debounce_fsm #(.DEBOUNCE(DEBOUNCE)) u_fsm (
        .clk(clk), .rst(rst), .scan_done(scan_done), .scan_vec(scan_vec),
        .key_valid(key_valid), .key_down(key_down), .key_code(key_code)
    );
endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk #(
    parameter bit          STATIC_MODE = 1'b0,
    parameter int unsigned STATIC_COL  = 0
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] col_drive,
    input logic [3:0] key_code,
    input logic       key_valid,
    input logic       key_down
);
    a_r1_col_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(col_drive) == 1);

    a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);

    a_r5_valid_with_down: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> key_down);

    a_r7_code_stable: assert property (@(posedge clk) disable iff (rst)
        (key_down && $past(key_down)) |-> $stable(key_code));

    a_r8_no_strobe_while_held: assert property (@(posedge clk) disable iff (rst)
        key_valid |-> !$past(key_down));

    generate
        if (STATIC_MODE) begin : g_static_chk
            a_r2_static_col: assert property (@(posedge clk) disable iff (rst)
                col_drive == (3'b001 << STATIC_COL));
        end
    endgenerate
endmodule

bind keypad_scan keypad_scan_chk #(
    .STATIC_MODE(STATIC_MODE), .STATIC_COL(STATIC_COL)
) u_chk (
    .clk(clk), .rst(rst), .col_drive(col_drive), .key_code(key_code),
    .key_valid(key_valid), .key_down(key_down)
);

// File: tb/sim_keypad_scan.sv
`timescale 1ns/1ps
module sim_keypad_scan;
    localparam int DW   = 8;
    localparam int NDB  = 3;
    localparam int SCAN = DW * 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0]  col0, col1;
    logic [3:0]  row0, row1;
    logic [3:0]  code0, code1;
    logic        val0, val1, down0, down1;
    logic [11:0] keys0 = '0;
    logic [11:0] keys1 = '0;

    keypad_scan #(.DWELL(DW), .DEBOUNCE(NDB), .STATIC_MODE(1'b0), .STATIC_COL(0)) u0 (
        .clk(clk), .rst(rst), .col_drive(col0), .row_sense(row0),
        .key_code(code0), .key_valid(val0), .key_down(down0));

    keypad_scan #(.DWELL(DW), .DEBOUNCE(NDB), .STATIC_MODE(1'b1), .STATIC_COL(1)) u1 (
        .clk(clk), .rst(rst), .col_drive(col1), .row_sense(row1),
        .key_code(code1), .key_valid(val1), .key_down(down1));

    // physical pad: a pressed key connects its column to its row
    always_comb begin
        row0 = '0;
        row1 = '0;
        for (int c = 0; c < 3; c++) begin
            for (int r = 0; r < 4; r++) begin
                if (col0[c] && keys0[c*4+r]) row0[r] = 1'b1;
                if (col1[c] && keys1[c*4+r]) row1[r] = 1'b1;
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int legend(input int idx);
        case (idx)
            0: return 1;   1: return 4;   2: return 7;   3: return 12;
            4: return 2;   5: return 5;   6: return 8;   7: return 0;
            8: return 3;   9: return 6;  10: return 9;  11: return 14;
            default: return -1;
        endcase
    endfunction

    // behavioural reference, one per instance (m=1 is static on column 1)
    int          dc [2], ci [2], run [2], rel [2], cand [2];
    bit          held [2], ev [2], ed [2];
    int          ecode [2];
    logic [3:0]  h1 [2], h2 [2], rn [2];
    logic [11:0] part [2];

    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (rst) begin
                dc[m] = 0; ci[m] = 0; run[m] = 0; rel[m] = 0; cand[m] = 0;
                held[m] = 0; ev[m] = 0; ed[m] = 0; ecode[m] = 0;
                h1[m] = '0; h2[m] = '0; part[m] = '0;
            end else begin
                logic [3:0]  used;
                logic [11:0] vec;
                bit          done;
                int          col;
                used = h2[m];
                h2[m] = h1[m];
                h1[m] = rn[m];
                ev[m] = 0;
                done = 0;
                vec = '0;
                if (dc[m] == DW - 1) begin
                    col = (m == 1) ? 1 : ci[m];
                    vec = part[m];
                    vec[col*4 +: 4] = used;
                    if (m == 1 || col == 2) begin
                        done = 1;
                        part[m] = '0;
                    end else begin
                        part[m] = vec;
                    end
                    dc[m] = 0;
                    ci[m] = (ci[m] + 1) % 3;
                end else begin
                    dc[m] = dc[m] + 1;
                end
                if (done) begin
                    if (!held[m]) begin
                        if (run[m] == 0) begin
                            if (vec != 0) begin
                                for (int i = 11; i >= 0; i--) if (vec[i]) cand[m] = i;
                                run[m] = 1;
                            end
                        end else if (vec[cand[m]]) begin
                            run[m] = run[m] + 1;
                        end else begin
                            run[m] = 0;
                        end
                        if (run[m] == NDB) begin
                            ev[m] = 1; ed[m] = 1; held[m] = 1; run[m] = 0;
                            ecode[m] = legend(cand[m]);
                        end
                    end else begin
                        rel[m] = (vec == 0) ? rel[m] + 1 : 0;
                        if (rel[m] == NDB) begin
                            held[m] = 0; ed[m] = 0; rel[m] = 0;
                        end
                    end
                end
            end
        end
    end

    int pc0 = 0, pc1 = 0, lc0 = -1, lc1 = -1;

    always @(negedge clk) begin
        rn[0] = row0;
        rn[1] = row1;
        if (!rst && !finished) begin
            chk("R1 col_drive u0", col0 == (3'b001 << ci[0]), col0, 3'b001 << ci[0]);
            chk("R2 col_drive u1", col1 == 3'b010, col1, 3'b010);
            chk("R3 R5 key_valid u0", val0 == ev[0], val0, ev[0]);
            chk("R3 R5 key_valid u1", val1 == ev[1], val1, ev[1]);
            chk("R6 key_code u0", code0 == ecode[0][3:0], code0, ecode[0]);
            chk("R6 key_code u1", code1 == ecode[1][3:0], code1, ecode[1]);
            chk("R7 key_down u0", down0 == ed[0], down0, ed[0]);
            chk("R7 key_down u1", down1 == ed[1], down1, ed[1]);
            if (val0) begin pc0++; lc0 = code0; end
            if (val1) begin pc1++; lc1 = code1; end
        end
    end

    task automatic wait_scans(input int n);
        repeat (n * SCAN) @(posedge clk);
        #2;
    endtask

    initial begin
        int p;
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R9 reset col u0", col0 == 3'b001, col0, 1);
        chk("R9 reset col u1", col1 == 3'b010, col1, 2);
        chk("R9 reset outputs", {val0, down0, code0} == 6'd0, {val0, down0, code0}, 0);

        // steady press of key 5
        @(posedge clk); #2 keys0 = 12'b1 << 5;
        wait_scans(6);
        chk("R4 one press accepted", pc0 == 1, pc0, 1);
        chk("R6 code of key 5", lc0 == 5, lc0, 5);
        keys0 = '0;
        wait_scans(1);
        chk("R7 down held during release count", down0 == 1'b1, down0, 1);
        wait_scans(5);
        chk("R7 down cleared", down0 == 1'b0, down0, 0);

        // bouncing key 9 never reaches the count
        p = pc0;
        for (int k = 0; k < 4; k++) begin
            keys0 = 12'b1 << 10;
            wait_scans(1);
            keys0 = '0;
            wait_scans(1);
        end
        wait_scans(4);
        chk("R4 bounce rejected", pc0 == p, pc0, p);

        // every key position
        for (int i = 0; i < 12; i++) begin
            p = pc0;
            keys0 = 12'b1 << i;
            wait_scans(5);
            chk("R6 strobe per key", pc0 == p + 1, pc0, p + 1);
            chk("R6 legend per key", lc0 == legend(i), lc0, legend(i));
            keys0 = '0;
            wait_scans(5);
        end

        // two keys: 7 (index 2) and 3 (index 8)
        p = pc0;
        keys0 = (12'b1 << 2) | (12'b1 << 8);
        wait_scans(5);
        chk("R8 first in scan order", lc0 == 7, lc0, 7);
        keys0 = 12'b1 << 8;
        wait_scans(6);
        chk("R8 no strobe while pad busy", pc0 == p + 1, pc0, p + 1);
        chk("R8 down while pad busy", down0 == 1'b1, down0, 1);
        keys0 = '0;
        wait_scans(5);
        keys0 = 12'b1 << 8;
        wait_scans(5);
        chk("R8 new press after full release", pc0 == p + 2 && lc0 == 3, lc0, 3);
        keys0 = '0;
        wait_scans(5);

        // static instance: column 0 key ignored, column 1 key reported
        keys1 = 12'b1;
        wait_scans(6);
        chk("R2 other column ignored", pc1 == 0 && down1 == 1'b0, pc1, 0);
        keys1 = 12'b1 << 5;
        wait_scans(6);
        chk("R2 static key accepted", pc1 == 1 && lc1 == 5, lc1, 5);
        keys1 = '0;
        wait_scans(6);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule